// File: doc/BRIEF.md
# Half-Cut Hybrid Tree/Linear SAD Array

This datapath computes sum-of-absolute-difference distortions for block matching. The current block is N×N pixels and is written into the array beforehand. The block's columns are split into groups of M columns, and each group belongs to one stage. A stage forms the absolute differences of its pixels and reduces them in a balanced adder tree. The stage results then pass along a linear chain. Between neighbouring stages there is a delay line. Because of it, stage g adds its tree sum to the partial that stage g-1 produced for the same candidate M column steps earlier.

The array is shared in time by a factor of two. Each stage has (N/2)·M difference units. A column step ("beat") is made of two window transfers. The even transfer carries the even rows of M window columns and the odd transfer carries the odd rows. The even partial and the odd partial travel down the chain separately. A single accumulator after the last stage merges them: it loads on the even transfer and adds on the odd transfer. A strip is a run of window columns at one vertical offset. It is streamed one column step at a time, and each step adds one new window column to the right edge of the M-column input group. Each completed candidate produces one result on a valid/ready output.

Top module: `sadarr_top`

## Requirements
- R1: After reset, `sad_valid` is 0 and `win_ready` is 1.
- R2: For candidate x of a strip, `sad_data` equals the sum over rows r and columns c in 0..N-1 of |cur[r][c] − win[r][x+c]|, where win[r][k] is row r of window column k.
- R3: Lane L = j·(N/2)+i of `win_pix` (bits L·8 .. L·8+7) carries row 2i+φ of window column s+j, where s is the beat index within the strip and φ is the transfer phase. A transfer with `win_first` high is phase 0 of beat 0. After that, phases alternate 0,1,0,1 on accepted transfers, and the beat index increases by one after each phase-1 transfer.
- R4: Beats 0 .. N−M−1 of a strip produce no result. Beat s ≥ N−M yields candidate x = s−(N−M), and `sad_valid` rises in the cycle after that beat's phase-1 transfer. A strip of W columns (beats 0..W−M) therefore yields exactly W−N+1 results, in order of x.
- R5: A phase-0 transfer never loads `sad_data` and never raises `sad_valid`.
- R6: `win_ready` is high exactly when the output register is empty or is being taken. While `sad_valid` is high and `sad_ready` is low, `sad_valid` and `sad_data` hold and no window transfer is accepted.
- R7: A cycle in which `win_valid` is low does not change the array's state, so idle gaps inside a strip leave every result unchanged.
- R8: Asserting `win_first` in the middle of a strip abandons that strip. The new strip's results are exactly those of R4 for the new data, and nothing from the abandoned beats is emitted.
- R9: A write with `cur_we` high stores `cur_pix` at row `cur_row`, column `cur_col`, and it is used by all later transfers.
- R10: The extreme distortion N·N·255 (4080 for N=4) is produced exactly and never exceeds the 12-bit output, and an exact match produces 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_we | input | 1 | Current-block pixel write strobe |
| cur_row | input | 2 | Row of the pixel being written |
| cur_col | input | 2 | Column of the pixel being written |
| cur_pix | input | 8 | Pixel value being written |
| win_valid | input | 1 | Window transfer offered |
| win_ready | output | 1 | Window transfer accepted when high with win_valid |
| win_first | input | 1 | Transfer is phase 0 of beat 0 of a new strip |
| win_pix | input | 32 | (N/2)·M window pixels, lane layout as in R3 |
| sad_valid | output | 1 | Distortion result available |
| sad_ready | input | 1 | Consumer takes the result |
| sad_data | output | 12 | Distortion of the completed candidate |

## Verification
The output register can be emptied by the consumer in the same cycle that a phase-1 transfer refills it with the next candidate, and this handoff is where a lost or duplicated result would show. Table rows that toggle `sad_ready` in a repeating pattern, some of them also with idle gaps in the window stream, create both the simultaneous take-and-refill cycles and full stalls. The bench judges them by requiring exactly W−N+1 results per strip, in candidate order, each equal to its independently computed distortion. A directed stall also checks that the held result and `win_ready` stay frozen until the consumer returns.

// File: rtl/sadarr_pkg.sv
`timescale 1ns/1ps
package sadarr_pkg;
  localparam int PIX_W = 8;
  typedef logic [PIX_W-1:0] pix_t;
endpackage

// File: rtl/sadarr_tree.sv
`timescale 1ns/1ps
// Balanced reduction of LEAVES unsigned pixel-wide terms, heap layout.
module sadarr_tree
  import sadarr_pkg::*;
#(
  parameter int LEAVES = 4,
  parameter int SUM_W  = 12
) (
  input  logic [LEAVES*PIX_W-1:0] terms,
  output logic [SUM_W-1:0]        total
);
  localparam int P2    = 1 << $clog2(LEAVES);
  localparam int NODES = 2 * P2 - 1;

  logic [SUM_W-1:0] node [NODES];

  for (genvar i = 0; i < P2; i++) begin : g_leaf
    if (i < LEAVES) begin : g_used
      assign node[P2-1+i] = {{(SUM_W-PIX_W){1'b0}}, terms[i*PIX_W +: PIX_W]};
    end else begin : g_pad
      assign node[P2-1+i] = '0;
    end
  end

  for (genvar k = 0; k < P2 - 1; k++) begin : g_add
    assign node[k] = node[2*k+1] + node[2*k+2];
  end

  assign total = node[0];
endmodule

// File: rtl/sadarr_stage.sv
`timescale 1ns/1ps
// One column-group stage: absolute differences, tree, chain addition.
module sadarr_stage
  import sadarr_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SUM_W = 12
) (
  input  logic [LANES*PIX_W-1:0] win,
  input  logic [LANES*PIX_W-1:0] cur,
  input  logic [SUM_W-1:0]       chain_in,
  output logic [SUM_W-1:0]       part
);
  logic [LANES*PIX_W-1:0] diffs;
  logic [SUM_W-1:0]       tree_sum;

  for (genvar l = 0; l < LANES; l++) begin : g_pe
    pix_t a, b;
    assign a = win[l*PIX_W +: PIX_W];
    assign b = cur[l*PIX_W +: PIX_W];
    assign diffs[l*PIX_W +: PIX_W] = (a >= b) ? (a - b) : (b - a);
  end

  sadarr_tree #(.LEAVES(LANES), .SUM_W(SUM_W)) u_tree (
    .terms (diffs),
    .total (tree_sum)
  );

  assign part = tree_sum + chain_in;
endmodule

// File: rtl/sadarr_top.sv
`timescale 1ns/1ps
module sadarr_top
  import sadarr_pkg::*;
#(
  parameter int N = 4,
  parameter int M = 2,
  localparam int LANES = (N / 2) * M,
  localparam int IN_W  = LANES * PIX_W,
  localparam int SUM_W = PIX_W + $clog2(N * N),
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cur_we,
  input  logic [IDX_W-1:0] cur_row,
  input  logic [IDX_W-1:0] cur_col,
  input  logic [PIX_W-1:0] cur_pix,
  input  logic             win_valid,
  output logic             win_ready,
  input  logic             win_first,
  input  logic [IN_W-1:0]  win_pix,
  output logic             sad_valid,
  input  logic             sad_ready,
  output logic [SUM_W-1:0] sad_data
);
  localparam int G      = N / M;
  localparam int H      = N / 2;
  localparam int DLY    = 2 * M;
  localparam int THR    = (G - 1) * M;
  localparam int BEAT_W = $clog2(THR + 1) + 1;
  localparam logic [BEAT_W-1:0] THR_B = BEAT_W'(THR);

  // Preloaded current block
  pix_t cur_q [N][N];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++)
          cur_q[r][c] <= '0;
    end else if (cur_we) begin
      cur_q[cur_row][cur_col] <= cur_pix;
    end
  end

  // Stream handshake and beat/phase tracking
  logic              xfer;
  logic              phase_q, cur_phase;
  logic [BEAT_W-1:0] beat_q, cur_beat;
  logic              live_q, live, beat_ok;

  assign win_ready = !sad_valid || sad_ready;
  assign xfer      = win_valid && win_ready;
  assign cur_phase = win_first ? 1'b0 : phase_q;
  assign cur_beat  = win_first ? '0 : beat_q;
  assign live      = win_first || live_q;
  assign beat_ok   = live && (cur_beat >= THR_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      beat_q  <= '0;
      live_q  <= 1'b0;
    end else if (xfer) begin
      phase_q <= ~cur_phase;
      live_q  <= live;
      if (cur_phase && (cur_beat < THR_B)) beat_q <= cur_beat + 1'b1;
      else                                 beat_q <= cur_beat;
    end
  end

  // Stages and systolic chain
  logic [SUM_W-1:0] part  [G];
  logic [SUM_W-1:0] chain [G];

  for (genvar g = 0; g < G; g++) begin : g_stage
    logic [IN_W-1:0] cur_lane;
    for (genvar j = 0; j < M; j++) begin : g_col
      for (genvar i = 0; i < H; i++) begin : g_row
        assign cur_lane[(j*H+i)*PIX_W +: PIX_W] = cur_q[2*i + int'(cur_phase)][g*M + j];
      end
    end

    if (g == 0) begin : g_head
      assign chain[g] = '0;
    end else begin : g_link
      logic [SUM_W-1:0] sr [DLY];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < DLY; k++) sr[k] <= '0;
        end else if (xfer) begin
          sr[0] <= part[g-1];
          for (int k = 1; k < DLY; k++) sr[k] <= sr[k-1];
        end
      end
      assign chain[g] = sr[DLY-1];
    end

    sadarr_stage #(.LANES(LANES), .SUM_W(SUM_W)) u_stage (
      .win      (win_pix),
      .cur      (cur_lane),
      .chain_in (chain[g]),
      .part     (part[g])
    );
  end

  // Even/odd merge after the last stage
  logic [SUM_W-1:0] acc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      sad_valid <= 1'b0;
      sad_data  <= '0;
    end else begin
      if (xfer && !cur_phase) acc_q <= part[G-1];
      if (xfer && cur_phase) sad_valid <= beat_ok;
      else if (sad_ready)    sad_valid <= 1'b0;
      if (xfer && cur_phase && beat_ok) sad_data <= acc_q + part[G-1];
    end
  end
endmodule

// File: rtl/sadarr_chk.sv
`timescale 1ns/1ps
module sadarr_chk #(
  parameter int SUM_W  = 12,
  parameter int BEAT_W = 3,
  parameter int MAXV   = 4080
) (
  input logic              clk,
  input logic              rst_n,
  input logic              win_valid,
  input logic              win_ready,
  input logic              sad_valid,
  input logic              sad_ready,
  input logic [SUM_W-1:0]  sad_data,
  input logic              cur_phase,
  input logic              beat_ok,
  input logic              phase_q,
  input logic [BEAT_W-1:0] beat_q
);
  logic xfer_s;
  assign xfer_s = win_valid && win_ready;

  a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (sad_valid && !sad_ready) |=> (sad_valid && $stable(sad_data)));

  a_r6_no_step_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (sad_valid && !sad_ready) |=> ($stable(phase_q) && $stable(beat_q)));

  a_r5_even_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_s && !cur_phase) |=> ($stable(sad_data) && !$rose(sad_valid)));

  a_r4_no_early_result: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_s && cur_phase && !beat_ok) |=> !sad_valid);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_s |=> ($stable(phase_q) && $stable(beat_q)));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    sad_valid |-> (int'(sad_data) <= MAXV));
endmodule

bind sadarr_top sadarr_chk #(
  .SUM_W  (SUM_W),
  .BEAT_W (BEAT_W),
  .MAXV   (N * N * 255)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .win_valid (win_valid),
  .win_ready (win_ready),
  .sad_valid (sad_valid),
  .sad_ready (sad_ready),
  .sad_data  (sad_data),
  .cur_phase (cur_phase),
  .beat_ok   (beat_ok),
  .phase_q   (phase_q),
  .beat_q    (beat_q)
);

// File: tb/sadarr_top_bench.sv
`timescale 1ns/1ps
module sadarr_top_bench;
  localparam int N = 4, M = 2, H = N / 2, W = 8;
  localparam int NCAND = W - N + 1;
  localparam int BEATS = W - M + 1;
  localparam int NT = 6;
  // {cur kind, cur seed, win kind, win seed, gaps, back-pressure}
  localparam logic [31:0] TABLE [NT] = '{
    32'h0140_0A00, 32'h1071_5B10, 32'h1C81_0D01,
    32'h2002_FF00, 32'h24D2_4D00, 32'h12D0_7811 };

  logic        clk = 0, rst_n = 0;
  logic        cur_we = 0;
  logic [1:0]  cur_row = 0, cur_col = 0;
  logic [7:0]  cur_pix = 0;
  logic        win_valid = 0, win_first = 0, sad_ready = 1;
  logic [31:0] win_pix = 0;
  logic        win_ready, sad_valid;
  logic [11:0] sad_data;

  sadarr_top u_sadarr_top (
    .clk(clk), .rst_n(rst_n), .cur_we(cur_we), .cur_row(cur_row),
    .cur_col(cur_col), .cur_pix(cur_pix), .win_valid(win_valid),
    .win_ready(win_ready), .win_first(win_first), .win_pix(win_pix),
    .sad_valid(sad_valid), .sad_ready(sad_ready), .sad_data(sad_data));

  always #5 clk = ~clk;

  int total = 0, fails = 0, got_n = 0, cyc = 0, rdy_mode = 0;
  int got [32];
  int cur_m [N][N];
  int win_m [N][W];
  bit done = 0, send_done = 0;

  always @(posedge clk) begin
    cyc++;
    #1;
    case (rdy_mode)
      0: sad_ready = 1'b1;
      1: sad_ready = (cyc % 3) != 1;
      default: sad_ready = 1'b0;
    endcase
  end

  always @(negedge clk)
    if (rst_n && sad_valid && sad_ready) begin
      if (got_n < 32) got[got_n] = int'(sad_data);
      got_n++;
    end

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pix(int k, int s, int r, int c);
    case (k)
      0: return (s + 17*r + 5*c) & 255;
      1: return ((s*31 + r*97 + c*57) ^ (r*c*13 + s)) & 255;
      default: return s & 255;
    endcase
  endfunction

  function automatic int model(int x);
    int s = 0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        int d = cur_m[r][c] - win_m[r][x+c];
        s += (d < 0) ? -d : d;
      end
    return s;
  endfunction

  task automatic fill(int ck, int cs, int wk, int ws);
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) cur_m[r][c] = pix(ck, cs, r, c);
      for (int c = 0; c < W; c++) win_m[r][c] = pix(wk, ws, r, c);
    end
  endtask

  task automatic load_cur();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        cur_we = 1; cur_row = 2'(r); cur_col = 2'(c); cur_pix = 8'(cur_m[r][c]);
        @(posedge clk); #1;
      end
    cur_we = 0;
  endtask

  task automatic send(bit f, int s, int ph);
    bit ok;
    win_valid = 1; win_first = f;
    for (int j = 0; j < M; j++)
      for (int i = 0; i < H; i++)
        win_pix[(j*H+i)*8 +: 8] = 8'(win_m[2*i+ph][s+j]);
    do begin
      @(negedge clk); ok = win_ready;
      @(posedge clk); #1;
    end while (!ok);
    win_valid = 0; win_first = 0;
  endtask

  task automatic strip(int nbeats, bit gaps);
    for (int s = 0; s < nbeats; s++)
      for (int ph = 0; ph < 2; ph++) begin
        send(s == 0 && ph == 0, s, ph);
        if (gaps && ((s + ph) % 3 == 0)) begin @(posedge clk); #1; end
      end
  endtask

  task automatic wait_results(int n);
    for (int t = 0; t < 300 && got_n < n; t++) @(posedge clk);
    repeat (12) @(posedge clk);
  endtask

  task automatic judge(string tag);
    check(got_n == NCAND, "R4 result count", got_n, NCAND);
    for (int x = 0; x < NCAND; x++)
      check(got[x] == model(x), tag, got[x], model(x));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int d;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    check(sad_valid == 0, "R1 sad_valid after reset", int'(sad_valid), 0);
    check(win_ready == 1, "R1 win_ready after reset", int'(win_ready), 1);
    @(posedge clk); #1;

    // Table walk (R2/R3 values, R9 loads, R6/R7/R10 by row)
    for (int e = 0; e < NT; e++) begin
      logic [31:0] v = TABLE[e];
      string tag;
      fill(int'(v[31:28]), int'(v[27:20]), int'(v[19:16]), int'(v[15:8]));
      tag = (v[31:28] == 2) ? "R10 extreme value" :
            (v[3:0] != 0)   ? "R6 value under back-pressure" :
            (v[7:4] != 0)   ? "R7 value with idle gaps" : "R2/R3 candidate value";
      rdy_mode = (v[3:0] != 0) ? 1 : 0;
      load_cur();
      got_n = 0;
      strip(BEATS, v[7:4] != 0);
      wait_results(NCAND);
      judge(tag);
      rdy_mode = 0;
    end

    // R4/R5 cycle timing of the first result
    fill(1, 33, 1, 140);
    load_cur();
    repeat (2) @(posedge clk); #1;
    got_n = 0;
    for (int s = 0; s < 2; s++)
      for (int ph = 0; ph < 2; ph++) begin
        send(s == 0 && ph == 0, s, ph);
        @(negedge clk);
        check(sad_valid == 0, "R4 early beat silent", int'(sad_valid), 0);
        @(posedge clk); #1;
      end
    send(0, 2, 0);
    @(negedge clk);
    check(sad_valid == 0, "R5 even transfer no result", int'(sad_valid), 0);
    @(posedge clk); #1;
    send(0, 2, 1);
    @(negedge clk);
    check(sad_valid == 1, "R4 result after odd transfer", int'(sad_valid), 1);
    check(int'(sad_data) == model(0), "R4 first candidate", int'(sad_data), model(0));
    @(posedge clk); #1;
    for (int s = 3; s < BEATS; s++)
      for (int ph = 0; ph < 2; ph++) send(0, s, ph);
    wait_results(NCAND);
    judge("R2/R3 candidate value");

    // R8 restart mid-strip
    fill(1, 9, 0, 60);
    load_cur();
    got_n = 0;
    strip(2, 0);
    fill(1, 9, 1, 222);
    strip(BEATS, 0);
    wait_results(NCAND);
    check(got_n == NCAND, "R8 restart count", got_n, NCAND);
    for (int x = 0; x < NCAND; x++)
      check(got[x] == model(x), "R8 restart value", got[x], model(x));

    // R9 single-pixel rewrite takes effect
    cur_m[1][2] = 255 - cur_m[1][2];
    cur_we = 1; cur_row = 2'd1; cur_col = 2'd2; cur_pix = 8'(cur_m[1][2]);
    @(posedge clk); #1; cur_we = 0;
    got_n = 0;
    strip(BEATS, 0);
    wait_results(NCAND);
    check(got_n == NCAND, "R9 count", got_n, NCAND);
    for (int x = 0; x < NCAND; x++)
      check(got[x] == model(x), "R9 rewritten pixel", got[x], model(x));

    // R6 full stall
    fill(0, 5, 1, 77);
    load_cur();
    got_n = 0;
    rdy_mode = 2;
    @(posedge clk); #1;
    send_done = 0;
    fork
      begin strip(BEATS, 0); send_done = 1; end
    join_none
    repeat (30) @(negedge clk);
    check(sad_valid == 1, "R6 held valid", int'(sad_valid), 1);
    check(win_ready == 0, "R6 ready low in stall", int'(win_ready), 0);
    check(int'(sad_data) == model(0), "R6 held value", int'(sad_data), model(0));
    d = int'(sad_data);
    repeat (6) @(negedge clk);
    check(int'(sad_data) == d && sad_valid, "R6 stable in stall", int'(sad_data), d);
    check(got_n == 0, "R6 nothing taken", got_n, 0);
    rdy_mode = 0;
    wait (send_done);
    wait_results(NCAND);
    judge("R6 value after stall");

    done = 1;
    summary();
    $finish;
  end
endmodule